// File: doc/BRIEF.md
# UART transmitter with fill reporting

This block is the transmit half of an asynchronous serial port. Software pushes characters into a 16-deep queue through a small register-style write port. A shift engine takes them one at a time and sends them as asynchronous frames. Each frame has a start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit (even or odd) and one or two stop bits. The bit period is a fixed number of clock cycles, set by a parameter.

The number of characters waiting in the queue is always visible as a level output. Two status conditions can each raise the interrupt line under its own enable bit. The first is "drained": the queue is empty and the shifter has finished the last stop bit. The second is "low": the level is under a programmable threshold. A control bit holds the line in break. Another routes the serial stream to a separate loopback output that feeds the receiver, instead of the line pin. A self-clearing action bit discards all queued characters.

Writes with `wr_addr` = 0 push `wr_data[7:0]` into the queue. Writes with `wr_addr` = 1 load the control word.

Top module: `uart_tx_fill`

## Requirements
- R1: After reset the line and the loopback output are high, the level is 0, drained status is 1, the interrupt is 0, and every control field is 0, so transmission is disabled.
- R2: A frame is one start bit (0), then N data bits LSB first, where N = 5 + control bits [5:4]. A parity bit follows when bit 6 is set. It makes the count of ones even, or odd when bit 7 is set. Then come one stop bit (1), or two when bit 8 is set. Each bit lasts BIT_CYC clocks, and the format is fixed when the character leaves the queue.
- R3: Each data write to a queue that is not full stores one character, and the level output reports the stored count from 0 to DEPTH.
- R4: A data write to a full queue is ignored. The level stays at DEPTH and the stored characters are later sent complete and in write order.
- R5: While the enable bit (bit 0) is 0 no new frame starts. A frame already in flight is completed.
- R6: A control write with bit 3 set empties the queue in the same cycle. The discarded characters are never sent, and bit 3 is not stored.
- R7: Drained status is 1 exactly when the queue is empty and the shifter is idle, which is after the last stop bit.
- R8: Low status is 1 exactly when the level is below the threshold field, control bits [14:11].
- R9: The interrupt output is a registered OR of drained status gated by bit 9 and low status gated by bit 10. It follows them one clock later.
- R10: With bit 1 set, the line goes low at the next frame boundary (at once if idle) and stays low, and no frame starts. After bit 1 clears, the line stays low until a bit boundary. It is then high for at least one bit period before any frame.
- R11: With bit 2 set, the serial stream appears on `loop_out` and `tx_line` stays high. With bit 2 clear, `loop_out` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | 0 = push character, 1 = control word |
| wr_data | input | 11+$clog2(DEPTH) | Write data (character or control word) |
| tx_line | output | 1 | Serial line, idles high |
| loop_out | output | 1 | Serial stream toward the receiver in loopback |
| fill_level | output | $clog2(DEPTH+1) | Characters waiting in the queue |
| stat_drained | output | 1 | Queue empty and shifter idle |
| stat_low | output | 1 | Level below threshold |
| irq | output | 1 | Masked, registered interrupt request |

## Verification
The bench builds the block with DEPTH = 16 and BIT_CYC = 4. The four-clock bit period keeps a full 16-character drain short enough to run. It also keeps break release and the guard gap measurable at single-bit resolution. The full-size queue lets the bench reach the overflow write, the threshold crossing at half depth and the drained transition at the last stop bit. A table of six frame formats covers every data width, both parity senses, no parity and both stop lengths.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int CHAR_W    = 8;
    localparam int FRAME_MAX = 12;   // start + 8 data + parity + 2 stop

    // control word bit positions
    localparam int C_EN   = 0;
    localparam int C_BRK  = 1;
    localparam int C_LOOP = 2;
    localparam int C_CLR  = 3;
    localparam int C_DB   = 4;
    localparam int C_PE   = 6;
    localparam int C_PO   = 7;
    localparam int C_TS   = 8;
    localparam int C_MD   = 9;
    localparam int C_ML   = 10;
    localparam int C_THR  = 11;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_SEND,
        SH_BRK,
        SH_GAP
    } sh_state_e;

    typedef struct packed {
        logic       mask_low;
        logic       mask_drained;
        logic       two_stop;
        logic       par_odd;
        logic       par_en;
        logic [1:0] dbits;
        logic       loop;
        logic       brk;
        logic       tx_en;
    } tx_cfg_t;

    function automatic tx_cfg_t decode_ctrl(input logic [C_THR-1:0] w);
        tx_cfg_t c;
        c.tx_en        = w[C_EN];
        c.brk          = w[C_BRK];
        c.loop         = w[C_LOOP];
        c.dbits        = w[C_DB +: 2];
        c.par_en       = w[C_PE];
        c.par_odd      = w[C_PO];
        c.two_stop     = w[C_TS];
        c.mask_drained = w[C_MD];
        c.mask_low     = w[C_ML];
        return c;
    endfunction

    // line bits in send order, bit 0 first; unused upper bits are stop level
    function automatic logic [FRAME_MAX-1:0] build_frame(input logic [CHAR_W-1:0] d,
                                                         input tx_cfg_t c);
        logic [FRAME_MAX-1:0] f;
        logic                 p;
        int                   nb;
        nb   = 5 + int'(c.dbits);
        p    = c.par_odd;
        f    = '1;
        f[0] = 1'b0;
        for (int i = 0; i < CHAR_W; i++) begin
            if (i < nb) begin
                f[i+1] = d[i];
                p      = p ^ d[i];
            end
        end
        if (c.par_en) f[nb+1] = p;
        return f;
    endfunction

    function automatic logic [3:0] frame_len(input tx_cfg_t c);
        return 4'd7 + {2'b00, c.dbits} + {3'b000, c.par_en} + {3'b000, c.two_stop};
    endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH+1);
    localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] cnt;
    logic          push_ok, pop_ok;

    assign full    = (cnt == LVL_FULL);
    assign empty   = (cnt == '0);
    assign push_ok = push && !full && !clr;
    assign pop_ok  = pop && !empty && !clr;
    assign rdata   = mem[rp];
    assign level   = cnt;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= wp + 1'b1;
            if (pop_ok)  rp <= rp + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    a_r4_full_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !clr) |=> (level == LVL_FULL));

    a_r6_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> empty);

    a_r3_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_FULL);

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int BIT_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  tx_cfg_t           cfg,
    input  logic              fifo_empty,
    input  logic [CHAR_W-1:0] fifo_data,
    output logic              pop,
    output logic              line,
    output logic              idle
);
    localparam int CW = $clog2(BIT_CYC);
    localparam logic [CW-1:0] CNT_TOP = CW'(BIT_CYC - 1);

    sh_state_e            state;
    logic [FRAME_MAX-1:0] shreg;
    logic [3:0]           left;
    logic [CW-1:0]        cnt;
    logic                 bit_end;

    assign bit_end = (cnt == '0);
    assign pop     = (state == SH_IDLE) && cfg.tx_en && !cfg.brk && !fifo_empty;
    assign idle    = (state == SH_IDLE);

    always_comb begin
        case (state)
            SH_SEND: line = shreg[0];
            SH_BRK:  line = 1'b0;
            default: line = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SH_IDLE;
            shreg <= '1;
            left  <= '0;
            cnt   <= '0;
        end else begin
            case (state)
                SH_IDLE: begin
                    if (cfg.brk) begin
                        state <= SH_BRK;
                        cnt   <= CNT_TOP;
                    end else if (pop) begin
                        state <= SH_SEND;
                        shreg <= build_frame(fifo_data, cfg);
                        left  <= frame_len(cfg);
                        cnt   <= CNT_TOP;
                    end
                end
                SH_SEND: begin
                    if (bit_end) begin
                        if (left == 4'd1) begin
                            state <= SH_IDLE;
                        end else begin
                            shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
                            left  <= left - 1'b1;
                            cnt   <= CNT_TOP;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SH_BRK: begin
                    if (bit_end) begin
                        cnt <= CNT_TOP;
                        if (!cfg.brk) state <= SH_GAP;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (bit_end) state <= SH_IDLE;
                    else         cnt   <= cnt - 1'b1;
                end
            endcase
        end
    end

    a_r5_no_start_when_disabled: assert property (@(posedge clk) disable iff (rst)
        (state == SH_IDLE && !cfg.tx_en) |=> (state != SH_SEND));

    a_r10_break_holds: assert property (@(posedge clk) disable iff (rst)
        (state == SH_BRK && cfg.brk) |=> (state == SH_BRK));

    a_r10_gap_before_frame: assert property (@(posedge clk) disable iff (rst)
        (state == SH_BRK) |=> (state != SH_SEND && state != SH_IDLE));

endmodule

// File: rtl/uart_tx_status.sv
module uart_tx_status #(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [$clog2(DEPTH+1)-1:0] level,
    input  logic [$clog2(DEPTH)-1:0]   thr,
    input  logic                       fifo_empty,
    input  logic                       sh_idle,
    input  logic                       mask_drained,
    input  logic                       mask_low,
    output logic                       stat_drained,
    output logic                       stat_low,
    output logic                       irq
);
    localparam int LW = $clog2(DEPTH+1);

    assign stat_drained = fifo_empty && sh_idle;
    assign stat_low     = (level < LW'(thr));

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= (stat_drained && mask_drained) || (stat_low && mask_low);
    end

    a_r9_irq_masked_off: assert property (@(posedge clk) disable iff (rst)
        (!mask_drained && !mask_low) |=> !irq);

endmodule

// File: rtl/uart_tx_fill.sv
module uart_tx_fill
    import uart_tx_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int BIT_CYC = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic                            wr_addr,
    input  logic [C_THR+$clog2(DEPTH)-1:0]  wr_data,
    output logic                            tx_line,
    output logic                            loop_out,
    output logic [$clog2(DEPTH+1)-1:0]      fill_level,
    output logic                            stat_drained,
    output logic                            stat_low,
    output logic                            irq
);
    localparam int THR_W = $clog2(DEPTH);

    tx_cfg_t           cfg_q;
    logic [THR_W-1:0]  thr_q;
    logic              ctrl_wr, data_wr, fifo_clr;
    logic              fifo_empty, fifo_full, pop, line_raw, sh_idle;
    logic [CHAR_W-1:0] fifo_data;

    assign ctrl_wr  = wr_en && wr_addr;
    assign data_wr  = wr_en && !wr_addr;
    assign fifo_clr = ctrl_wr && wr_data[C_CLR];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            thr_q <= '0;
        end else if (ctrl_wr) begin
            cfg_q <= decode_ctrl(wr_data[C_THR-1:0]);
            thr_q <= wr_data[C_THR +: THR_W];
        end
    end

    uart_tx_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (fifo_clr),
        .push  (data_wr),
        .wdata (wr_data[CHAR_W-1:0]),
        .pop   (pop),
        .rdata (fifo_data),
        .level (fill_level),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    uart_tx_shifter #(.BIT_CYC(BIT_CYC)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg_q),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .pop        (pop),
        .line       (line_raw),
        .idle       (sh_idle)
    );

    uart_tx_status #(.DEPTH(DEPTH)) u_stat (
        .clk          (clk),
        .rst          (rst),
        .level        (fill_level),
        .thr          (thr_q),
        .fifo_empty   (fifo_empty),
        .sh_idle      (sh_idle),
        .mask_drained (cfg_q.mask_drained),
        .mask_low     (cfg_q.mask_low),
        .stat_drained (stat_drained),
        .stat_low     (stat_low),
        .irq          (irq)
    );

    assign tx_line  = cfg_q.loop ? 1'b1 : line_raw;
    assign loop_out = cfg_q.loop ? line_raw : 1'b1;

    a_r7_drained_means_no_data: assert property (@(posedge clk) disable iff (rst)
        stat_drained |-> (fill_level == '0));

    a_r4_full_flag_level: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> (fill_level == ($clog2(DEPTH+1))'(DEPTH)));

endmodule

// File: tb/tb_uart_tx_fill.sv
module tb_uart_tx_fill;

    localparam int BIT   = 4;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [14:0] wr_data = '0;
    logic        tx_line, loop_out, stat_drained, stat_low, irq;
    logic [4:0]  fill_level;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    uart_tx_fill #(.DEPTH(DEPTH), .BIT_CYC(BIT)) dut (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .tx_line      (tx_line),
        .loop_out     (loop_out),
        .fill_level   (fill_level),
        .stat_drained (stat_drained),
        .stat_low     (stat_low),
        .irq          (irq)
    );

    // {dbits code[1:0], parity en, odd, two stop, char[7:0]}
    localparam logic [12:0] VEC [0:5] = '{
        {2'd3, 1'b0, 1'b0, 1'b0, 8'hA5},
        {2'd2, 1'b1, 1'b0, 1'b0, 8'h35},
        {2'd0, 1'b1, 1'b1, 1'b1, 8'h13},
        {2'd1, 1'b1, 1'b0, 1'b1, 8'h2C},
        {2'd3, 1'b1, 1'b1, 1'b0, 8'hFF},
        {2'd2, 1'b0, 1'b0, 1'b1, 8'h00}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [14:0] ctl(input bit en, input bit brk, input bit lp, input bit clr,
                                        input int db, input bit pe, input bit po, input bit ts,
                                        input bit md, input bit ml, input int thr);
        logic [14:0] w;
        w        = '0;
        w[0]     = en;
        w[1]     = brk;
        w[2]     = lp;
        w[3]     = clr;
        w[5:4]   = db[1:0];
        w[6]     = pe;
        w[7]     = po;
        w[8]     = ts;
        w[9]     = md;
        w[10]    = ml;
        w[14:11] = thr[3:0];
        return w;
    endfunction

    // called just after a negedge; returns one clock later, after the write edge
    task automatic wr(input bit a, input logic [14:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic logic ln(input bit lp);
        return lp ? loop_out : tx_line;
    endfunction

    task automatic rx_frame(input bit lp, input int nb, input bit pe, input bit po, input bit ts,
                            output int data, output int ok);
        int t;
        int p;
        t    = 0;
        data = 0;
        ok   = 1;
        while (ln(lp) != 1'b0 && t < 4000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 4000) begin
            ok = 0;
            return;
        end
        repeat (BIT/2) @(negedge clk);
        if (ln(lp) != 1'b0) ok = 0;
        p = 0;
        for (int i = 0; i < nb; i++) begin
            repeat (BIT) @(negedge clk);
            data = data | (int'(ln(lp)) << i);
            p    = p ^ int'(ln(lp));
        end
        if (pe) begin
            repeat (BIT) @(negedge clk);
            if (int'(ln(lp)) != (po ? (p ^ 1) : p)) ok = 0;
        end
        repeat (BIT) @(negedge clk);
        if (ln(lp) != 1'b1) ok = 0;
        if (ts) begin
            repeat (BIT) @(negedge clk);
            if (ln(lp) != 1'b1) ok = 0;
        end
    endtask

    task automatic quiet(input int n, input bit lp, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (ln(lp) == 1'b0) lows++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int d, ok, lows, run;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1", "tx_line", int'(tx_line), 1);
        chk("R1", "loop_out", int'(loop_out), 1);
        chk("R1", "fill", int'(fill_level), 0);
        chk("R1", "drained", int'(stat_drained), 1);
        chk("R1", "irq", int'(irq), 0);

        // R2 frame formats from the table
        for (int v = 0; v < 6; v++) begin
            int nb;
            nb = 5 + int'(VEC[v][12:11]);
            wr(1'b1, ctl(1, 0, 0, 0, int'(VEC[v][12:11]), VEC[v][10], VEC[v][9], VEC[v][8], 0, 0, 0));
            wr(1'b0, {7'd0, VEC[v][7:0]});
            rx_frame(1'b0, nb, VEC[v][10], VEC[v][9], VEC[v][8], d, ok);
            chk("R2", $sformatf("vec%0d data", v), d, int'(VEC[v][7:0]) & ((1 << nb) - 1));
            chk("R2", $sformatf("vec%0d framing", v), ok, 1);
            repeat (3 * BIT) @(negedge clk);
        end

        // R3 level, R8 threshold, R9 interrupt
        wr(1'b1, ctl(0, 0, 0, 0, 3, 0, 0, 0, 0, 1, 8));
        for (int i = 0; i < 5; i++) wr(1'b0, 15'(8'h40 + i));
        chk("R3", "fill after 5", int'(fill_level), 5);
        chk("R7", "drained with data", int'(stat_drained), 0);
        chk("R8", "low at 5 of 8", int'(stat_low), 1);
        @(negedge clk);
        chk("R9", "irq low source", int'(irq), 1);
        for (int i = 5; i < 8; i++) wr(1'b0, 15'(8'h40 + i));
        chk("R8", "low at 8 of 8", int'(stat_low), 0);
        @(negedge clk);
        chk("R9", "irq cleared", int'(irq), 0);

        // R4 overflow write ignored
        for (int i = 8; i < 16; i++) wr(1'b0, 15'(8'h40 + i));
        wr(1'b0, 15'h0EE);
        chk("R4", "fill at full", int'(fill_level), 16);
        wr(1'b1, ctl(1, 0, 0, 0, 3, 0, 0, 0, 0, 0, 0));
        ok = 1;
        for (int i = 0; i < 15; i++) begin
            int k;
            rx_frame(1'b0, 8, 0, 0, 0, d, k);
            if (d != 8'h40 + i || k != 1) ok = 0;
        end
        while (tx_line != 1'b0) @(negedge clk);
        chk("R7", "drained during last frame", int'(stat_drained), 0);
        chk("R3", "fill during last frame", int'(fill_level), 0);
        rx_frame(1'b0, 8, 0, 0, 0, d, run);
        if (d != 8'h4F || run != 1) ok = 0;
        chk("R4", "sixteen in order", ok, 1);
        quiet(3 * BIT, 1'b0, lows);
        chk("R4", "no extra frame", lows, 0);
        chk("R7", "drained after stop", int'(stat_drained), 1);
        wr(1'b1, ctl(1, 0, 0, 0, 3, 0, 0, 0, 1, 0, 0));
        @(negedge clk);
        chk("R9", "irq drained source", int'(irq), 1);

        // R5 disable during a frame
        wr(1'b1, ctl(0, 0, 0, 0, 3, 0, 0, 0, 0, 0, 0));
        wr(1'b0, 15'h011);
        wr(1'b0, 15'h022);
        wr(1'b1, ctl(1, 0, 0, 0, 3, 0, 0, 0, 0, 0, 0));
        wr(1'b1, ctl(0, 0, 0, 0, 3, 0, 0, 0, 0, 0, 0));
        rx_frame(1'b0, 8, 0, 0, 0, d, ok);
        chk("R5", "frame in flight", d, 8'h11);
        quiet(4 * BIT, 1'b0, lows);
        chk("R5", "no new frame", lows, 0);
        chk("R5", "second kept", int'(fill_level), 1);

        // R10 break
        wr(1'b1, ctl(1, 1, 0, 0, 3, 0, 0, 0, 0, 0, 0));
        @(negedge clk);
        chk("R10", "line low in break", int'(tx_line), 0);
        quiet(6 * BIT, 1'b0, lows);
        chk("R10", "held low", lows, 6 * BIT);
        chk("R10", "no frame in break", int'(fill_level), 1);
        wr(1'b1, ctl(1, 0, 0, 0, 3, 0, 0, 0, 0, 0, 0));
        run = 0;
        while (tx_line == 1'b0 && run < 100) begin
            @(negedge clk);
            run++;
        end
        chk("R10", "release within bit", int'(run <= BIT), 1);
        run = 0;
        while (tx_line == 1'b1 && run < 100) begin
            @(negedge clk);
            run++;
        end
        chk("R10", "guard high >= bit", int'(run >= BIT), 1);
        rx_frame(1'b0, 8, 0, 0, 0, d, ok);
        chk("R10", "frame after break", d, 8'h22);

        // R11 loopback
        repeat (3 * BIT) @(negedge clk);
        wr(1'b1, ctl(1, 0, 1, 0, 3, 1, 0, 0, 0, 0, 0));
        wr(1'b0, 15'h05A);
        fork
            rx_frame(1'b1, 8, 1, 0, 0, d, ok);
            quiet(14 * BIT, 1'b0, lows);
        join
        chk("R11", "loop data", d, 8'h5A);
        chk("R11", "loop framing", ok, 1);
        chk("R11", "pin quiet", lows, 0);
        wr(1'b1, ctl(0, 0, 0, 0, 3, 0, 0, 0, 0, 0, 0));

        // R6 queue clear
        for (int i = 0; i < 3; i++) wr(1'b0, 15'(8'h70 + i));
        chk("R3", "fill 3", int'(fill_level), 3);
        wr(1'b1, ctl(0, 0, 0, 1, 3, 0, 0, 0, 0, 0, 0));
        chk("R6", "fill after clear", int'(fill_level), 0);
        wr(1'b1, ctl(1, 0, 0, 0, 3, 0, 0, 0, 0, 0, 0));
        quiet(4 * BIT, 1'b0, lows);
        chk("R6", "nothing sent", lows, 0);
        chk("R6", "drained", int'(stat_drained), 1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule